// File: doc/BRIEF.md
# Modified-Line Directory for an Aliased Device Memory

This block sits beside an accelerator's on-board memory that the host sees through two address windows aliasing the same storage: one window takes host stores only, the other serves host cache-line reads only. The block holds no data. It keeps one bit per 64-byte line of a 32 KiB tracked region (512 lines). A bit is set when a host store arrives through the write window or when the device's own logic updates that line. Read-window traffic never sets a bit. This gives the host a record of which lines it must invalidate in its caches before it reads fresh data.

At the end of a tracking phase the host fetches the whole directory as one 64-byte line. The block hands it out as a valid/ready stream of eight 64-bit beats, starting with the lowest line indices. A one-cycle clear pulse then starts a new phase with every line clean. The map for a readout is frozen in a snapshot when the readout starts, so marks never stall. The two marking inputs carry no ready: both can mark in the same cycle and both marks are applied. The readout stream follows normal valid/ready rules. Once `map_valid` is high, the beat and `map_last` hold steady until `map_ready` is seen high at a clock edge. A beat moves only on that handshake.

Top module: `dirty_line_map`

## Requirements
- R1: After reset the map is all clean, `map_valid` is 0 and `oor_flag` is 0.
- R2: A host request with `host_req_write`=1 to byte offset A below 32768 sets the bit for line A>>6 from the next clock edge. Bits 5:0 of A are ignored, so a store of any size marks its whole line.
- R3: A device update with `dev_upd_valid`=1 to byte offset A below 32768 sets the bit for line A>>6 in the same way.
- R4: A host request with `host_req_write`=0 is a read-window access. It sets no bit and never raises `oor_flag`.
- R5: A host store and a device update in the same cycle are both applied by bitwise OR, including when both hit the same line. Neither input can be stalled.
- R6: Bits accumulate until a `phase_clr` pulse, which empties the map at that edge. A mark presented in the same cycle as the clear is kept in the new phase.
- R7: A `map_rd_start` pulse while idle starts a readout of 8 beats of 64 bits. Beat k carries lines 64k to 64k+63, and bit j of the beat is line 64k+j. `map_last` is 1 on beat 7 only, and `map_valid` drops after beat 7 is accepted.
- R8: While `map_valid`=1 and `map_ready`=0, `map_data` and `map_last` hold steady. A `map_rd_start` during a readout is ignored and adds no beats.
- R9: A readout shows the map as registered just before its start edge. Marks presented in the start cycle or during the readout do not appear in it, but they are in the live map for the next readout. A clear in the start cycle gives an atomic read-and-clear.
- R10: A marking request (host store or device update) to byte offset 32768 or above leaves the map unchanged and sets `oor_flag` high for the one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req_valid | input | 1 | Host access present this cycle |
| host_req_write | input | 1 | 1 = write-window store, 0 = read-window access |
| host_req_addr | input | 20 | Host byte offset into the aliased region |
| dev_upd_valid | input | 1 | Device-side update present this cycle |
| dev_upd_addr | input | 20 | Device update byte offset |
| phase_clr | input | 1 | One-cycle pulse that starts a new phase |
| map_rd_start | input | 1 | One-cycle pulse that starts a directory readout |
| map_valid | output | 1 | Readout beat is valid |
| map_ready | input | 1 | Consumer accepts the beat |
| map_data | output | 64 | Readout beat, one bit per line |
| map_last | output | 1 | Final beat of a readout |
| oor_flag | output | 1 | Marking request fell outside the tracked region |

## Verification
The hardest cases to reach are the races between the frozen snapshot and the live map. These are a mark in the exact start cycle, marks that land while the stream is stalled, and a clear that shares the start edge. The bench times these through a driver task that updates its reference map and queues the expected beats in the same cycle it pulses start. The consumer's ready follows a fixed stall pattern, so marks and a second start pulse fall inside back-pressured beats. A later readout then shows whether those marks reached the live map without leaking into the earlier snapshot.

// File: rtl/dlm_pkg.sv
package dlm_pkg;
  typedef enum logic {RD_IDLE, RD_BUSY} rd_state_e;
  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/line_mark_decode.sv
module line_mark_decode #(
  parameter int unsigned AW        = 20,
  parameter int unsigned OFF_W     = 6,
  parameter int unsigned IDX_W     = 9,
  parameter int unsigned NUM_LINES = 512
) (
  input  logic                 req_valid,
  input  logic                 mark_en,
  input  logic [AW-1:0]        addr,
  output logic [NUM_LINES-1:0] mark_vec,
  output logic                 oor
);
  logic [AW-1:0]    line_num;
  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic             marking;

  always_comb begin
    line_num = addr >> OFF_W;
    idx      = line_num[IDX_W-1:0];
    in_range = ((line_num >> IDX_W) == '0);
    marking  = req_valid && mark_en;
    oor      = marking && !in_range;
    mark_vec = '0;
    if (marking && in_range)
      mark_vec = {{(NUM_LINES-1){1'b0}}, 1'b1} << idx;
  end
endmodule

// File: rtl/dirty_bitmap.sv
module dirty_bitmap #(
  parameter int unsigned NUM_LINES = 512,
  parameter int unsigned NSRC      = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [NUM_LINES-1:0] marks [NSRC],
  output logic [NUM_LINES-1:0] map_q
);
  logic [NUM_LINES-1:0] mark_all;

  always_comb begin
    mark_all = '0;
    for (int s = 0; s < NSRC; s++) mark_all = mark_all | marks[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   map_q <= '0;
    else if (clr) map_q <= mark_all;
    else          map_q <= map_q | mark_all;
  end

  // R2/R3/R5: every presented mark is set after the edge
  a_r5_marks_land: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_all != '0) |=> ((map_q & $past(mark_all)) == $past(mark_all)));
  // R6: a clear with no marks leaves an empty map
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && mark_all == '0) |=> (map_q == '0));
  // R6: no clear and no marks keeps the map unchanged
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && mark_all == '0) |=> $stable(map_q));
endmodule

// File: rtl/map_readout.sv
module map_readout
  import dlm_pkg::*;
#(
  parameter int unsigned NUM_LINES = 512,
  parameter int unsigned BEAT_W    = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NUM_LINES-1:0] live_map,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [BEAT_W-1:0]    out_data,
  output logic                 out_last
);
  localparam int unsigned BEATS = NUM_LINES / BEAT_W;
  localparam int unsigned BW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  rd_state_e            state_q;
  logic [NUM_LINES-1:0] snap_q;
  logic [BW-1:0]        beat_q;
  logic                 fire;

  always_comb begin
    out_valid = (state_q == RD_BUSY);
    out_data  = snap_q[beat_q*BEAT_W +: BEAT_W];
    out_last  = (beat_q == BW'(BEATS-1));
    fire      = out_valid && out_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      snap_q  <= '0;
      beat_q  <= '0;
    end else begin
      case (state_q)
        RD_IDLE: if (start) begin
          snap_q  <= live_map;
          beat_q  <= '0;
          state_q <= RD_BUSY;
        end
        RD_BUSY: if (fire) begin
          if (out_last) state_q <= RD_IDLE;
          else          beat_q  <= beat_q + 1'b1;
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  // R8: stalled beat holds
  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  // R9: snapshot frozen for the whole readout
  a_r9_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> $stable(snap_q));
  // R7: accepted last beat ends the readout
  a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_last) |=> !out_valid);
endmodule

// File: rtl/dirty_line_map.sv
module dirty_line_map
  import dlm_pkg::*;
#(
  parameter int unsigned AW         = 20,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned NUM_LINES  = 512,
  parameter int unsigned BEAT_W     = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  input  logic              host_req_write,
  input  logic [AW-1:0]     host_req_addr,
  input  logic              dev_upd_valid,
  input  logic [AW-1:0]     dev_upd_addr,
  input  logic              phase_clr,
  input  logic              map_rd_start,
  output logic              map_valid,
  input  logic              map_ready,
  output logic [BEAT_W-1:0] map_data,
  output logic              map_last,
  output logic              oor_flag
);
  localparam int unsigned OFF_W = $clog2(LINE_BYTES);
  localparam int unsigned IDX_W = $clog2(NUM_LINES);

  logic                 src_valid [NUM_SRC];
  logic                 src_en    [NUM_SRC];
  logic [AW-1:0]        src_addr  [NUM_SRC];
  logic [NUM_LINES-1:0] src_mark  [NUM_SRC];
  logic [NUM_SRC-1:0]   src_oor;
  logic [NUM_LINES-1:0] live_map;
  logic                 oor_q;

  always_comb begin
    src_valid[0] = host_req_valid;
    src_en[0]    = host_req_write;
    src_addr[0]  = host_req_addr;
    src_valid[1] = dev_upd_valid;
    src_en[1]    = 1'b1;
    src_addr[1]  = dev_upd_addr;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    line_mark_decode #(
      .AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W), .NUM_LINES(NUM_LINES)
    ) u_dec (
      .req_valid(src_valid[s]),
      .mark_en  (src_en[s]),
      .addr     (src_addr[s]),
      .mark_vec (src_mark[s]),
      .oor      (src_oor[s])
    );
  end

  dirty_bitmap #(.NUM_LINES(NUM_LINES), .NSRC(NUM_SRC)) u_map (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (phase_clr),
    .marks(src_mark),
    .map_q(live_map)
  );

  map_readout #(.NUM_LINES(NUM_LINES), .BEAT_W(BEAT_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (map_rd_start),
    .live_map (live_map),
    .out_valid(map_valid),
    .out_ready(map_ready),
    .out_data (map_data),
    .out_last (map_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) oor_q <= 1'b0;
    else        oor_q <= |src_oor;
  end
  assign oor_flag = oor_q;

  // R10: out-of-range request changes nothing in the map
  a_r10_oor_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_oor && !phase_clr && (src_mark[0] | src_mark[1]) == '0) |=> $stable(live_map));
  // R4: read-window access never flags
  a_r4_read_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req_valid && !host_req_write && !dev_upd_valid) |=> !oor_flag);
endmodule

// File: tb/tb_dirty_line_map.sv
module tb_dirty_line_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req_valid = 1'b0, host_req_write = 1'b0;
  logic [19:0] host_req_addr = '0;
  logic        dev_upd_valid = 1'b0;
  logic [19:0] dev_upd_addr = '0;
  logic        phase_clr = 1'b0, map_rd_start = 1'b0;
  logic        map_valid, map_ready = 1'b0, map_last, oor_flag;
  logic [63:0] map_data;

  int checks = 0;
  int errors = 0;
  logic [511:0] model = '0;
  logic [64:0]  exp_q [$];
  string        tag_q [$];
  int unsigned  rdy_cnt = 0;
  logic         prev_stall = 1'b0;
  logic [64:0]  prev_beat = '0;

  always #5 clk = ~clk;

  dirty_line_map dut (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard, also drives ready
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk(map_valid && {map_last, map_data} == prev_beat, "R8 stall hold",
            {map_last, map_data}, prev_beat);
      rdy_cnt++;
      map_ready = (rdy_cnt % 3) != 2;
      prev_stall = map_valid && !map_ready;
      prev_beat  = {map_last, map_data};
      if (map_valid && map_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected beat", {map_last, map_data}, 0);
        end else begin
          logic [64:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({map_last, map_data} == e, t, {map_last, map_data}, e);
        end
      end
    end
  end

  function automatic bit in_rng(input logic [19:0] a);
    return a < 20'd32768;
  endfunction

  // one driven cycle; starts at a negedge
  task automatic cyc(input bit hv, input bit hw, input logic [19:0] ha,
                     input bit dv, input logic [19:0] da,
                     input bit clr, input bit start, input bit push, input string tag);
    bit exp_oor;
    host_req_valid = hv; host_req_write = hw; host_req_addr = ha;
    dev_upd_valid = dv; dev_upd_addr = da;
    phase_clr = clr; map_rd_start = start;
    exp_oor = (hv && hw && !in_rng(ha)) || (dv && !in_rng(da));
    if (start && push)
      for (int k = 0; k < 8; k++) begin
        exp_q.push_back({(k == 7), model[k*64 +: 64]});
        tag_q.push_back(tag);
      end
    if (clr) model = '0;
    if (hv && hw && in_rng(ha)) model[ha[14:6]] = 1'b1;
    if (dv && in_rng(da)) model[da[14:6]] = 1'b1;
    @(negedge clk);
    host_req_valid = 0; dev_upd_valid = 0; phase_clr = 0; map_rd_start = 0;
    chk(oor_flag == exp_oor, "R10 oor flag", oor_flag, exp_oor);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      if (exp_q.size() == 0 && !map_valid) break;
      @(negedge clk);
    end
    chk(exp_q.size() == 0 && !map_valid, "R7 readout complete", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!map_valid && !oor_flag, "R1 reset outputs", {map_valid, oor_flag}, 0);
    cyc(0,0,0, 0,0, 0,1,1, "R1 clean map");
    wait_idle();

    // R2 host stores, R3 device, R4 read window, R5 both, R10 out of range
    cyc(1,1,20'h00000, 0,0, 0,0,0, "");
    cyc(1,1,20'h0003F, 0,0, 0,0,0, "");
    cyc(1,1,20'h00040, 0,0, 0,0,0, "");
    cyc(1,1,20'h07FC0, 0,0, 0,0,0, "");
    cyc(1,1,20'h01234, 0,0, 0,0,0, "");
    cyc(0,0,0, 1,20'h02000, 0,0,0, "");
    cyc(1,0,20'h00800, 0,0, 0,0,0, "");
    cyc(1,0,20'h09000, 0,0, 0,0,0, "");
    cyc(1,1,20'h00C00, 1,20'h00C40, 0,0,0, "");
    cyc(1,1,20'h03000, 1,20'h03010, 0,0,0, "");
    cyc(1,1,20'h08000, 0,0, 0,0,0, "");
    cyc(0,0,0, 1,20'hFFFFF, 0,0,0, "");
    cyc(1,1,20'h10040, 1,20'h00100, 0,0,0, "");
    cyc(0,0,0, 0,0, 0,1,1, "R2/R3/R4/R5/R10 map beats");
    wait_idle();

    // R9 snapshot race and R8 ignored start
    cyc(1,1,20'h00140, 0,0, 0,1,1, "R9 snapshot excludes start-cycle mark");
    cyc(0,0,0, 1,20'h03200, 0,0,0, "");
    cyc(1,1,20'h04400, 0,0, 0,1,0, "");
    cyc(0,0,0, 1,20'h05000, 0,0,0, "");
    wait_idle();
    cyc(0,0,0, 0,0, 0,1,1, "R9 later readout shows live marks");
    wait_idle();

    // R6 clear with simultaneous mark, then atomic read-and-clear
    cyc(0,0,0, 1,20'h04B00, 1,0,0, "");
    cyc(0,0,0, 0,0, 0,1,1, "R6 clear keeps same-cycle mark");
    wait_idle();
    cyc(0,0,0, 0,0, 1,1,1, "R6 read-and-clear snapshot");
    wait_idle();
    cyc(0,0,0, 0,0, 0,1,1, "R6 map empty after clear");
    wait_idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule